// File: doc/BRIEF.md
# Sync-Framed Serial Word Receiver

This block is the receiving side of one channel of a serial data link. The host first selects the channel for receive. The block then hunts the incoming bit stream for a fixed 12-bit sync pattern. When the last bit of that pattern arrives, reception is armed. A 3-bit acknowledge code is then shifted back toward the sender, one bit per bit strobe. The sync bits themselves never reach the host.

While armed, the block shifts each group of 12 bits into an assembly register, MSB first. On the 12th bit it moves the finished word into a holding register and raises a Full/Receive flag for the polling host. The host has one word time to collect the word with a read strobe. If the next word finishes while the holding register is still unread, the block does not overwrite it. It ends the receive operation, raises a sticky terminated flag and goes idle. A new select and a new sync pattern are then needed before reception resumes.

Top module: `sync_word_rx`

## Requirements
- R1: After reset, `rx_armed`, `full_rcv`, `ack_active`, `ack_out` and `term_flag` are all 0.
- R2: Before any `sel_rx` pulse, incoming bits are ignored: a sync pattern followed by a data word leaves `rx_armed` and `full_rcv` at 0.
- R3: After `sel_rx`, `rx_armed` goes to 1 on the bit strobe that completes the sync pattern (default 12'hE2D, MSB first). The sync bits are not delivered as data: the first word the host reads is the 12 bits that follow the pattern.
- R4: After the sync strobe, `ack_active` is 1 for exactly 3 bit strobes. During that time `ack_out` carries the acknowledge code (default 3'b101), MSB first, and it changes on each strobe. Outside that window `ack_out` is 0.
- R5: Data bits are shifted in MSB first. On the strobe of the 12th bit, and not before, the word is copied to `rd_data` and `full_rcv` goes to 1.
- R6: A `rd_stb` pulse with no transfer in the same cycle clears `full_rcv` on that clock. `rd_data` shows the held word throughout.
- R7: If `rd_stb` is high in the same cycle as a transfer, that counts as a timely read: reception continues, `full_rcv` stays 1 and `rd_data` takes the new word.
- R8: If a word completes while `full_rcv` is 1 and `rd_stb` is low, `rx_armed` drops to 0 and `term_flag` goes to 1. `rd_data` keeps the unread word and `full_rcv` stays 1.
- R9: After termination, bits are ignored until a new `sel_rx`. `sel_rx` clears `term_flag`, and data is accepted again only after a fresh sync pattern.
- R10: Changes on `bit_in` while `bit_strobe` is low have no effect on the assembled word.
- R11: A data word whose value equals the sync pattern is delivered as ordinary data once reception is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_rx | input | 1 | Host select pulse: start hunting for sync and clear the terminated flag |
| bit_strobe | input | 1 | Marks a valid serial bit on `bit_in` |
| bit_in | input | 1 | Serial data in, MSB first |
| rd_stb | input | 1 | Host read pulse; clears the Full/Receive flag |
| rd_data | output | 12 | Holding register contents |
| full_rcv | output | 1 | Full/Receive status: an unread word is waiting |
| rx_armed | output | 1 | Sync has been seen and data words are being accepted |
| ack_out | output | 1 | Serial acknowledge bit toward the sender |
| ack_active | output | 1 | High while the acknowledge code is being sent |
| term_flag | output | 1 | Sticky: receive ended on an unread word |

## Verification
The hardest case to reach is a host read that lands in exactly the same clock as the 12th data bit, because two independent inputs must meet on one edge. The bench handles this by sending 11 bits of a word one at a time. It then raises `rd_stb` together with the final strobe, sampling `rd_data` before that edge and the flags after it. The overrun case is reached by leaving that new word unread and sending one more word. The bench then shows, at the ports, that the unread word survives and that later bits are ignored until a fresh select and sync.

// File: rtl/sync_word_rx.sv
module sync_word_rx #(
  parameter int                WORD_W    = 12,
  parameter logic [WORD_W-1:0] SYNC_WORD = 12'hE2D,
  parameter int                ACK_W     = 3,
  parameter logic [ACK_W-1:0]  ACK_CODE  = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_rx,
  input  logic              bit_strobe,
  input  logic              bit_in,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data,
  output logic              full_rcv,
  output logic              rx_armed,
  output logic              ack_out,
  output logic              ack_active,
  output logic              term_flag
);

  localparam int CNT_W  = $clog2(WORD_W);
  localparam int ACNT_W = $clog2(ACK_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_RECV} rx_state_t;

  rx_state_t         st_q;
  logic [WORD_W-1:0] win_q, asm_q, hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ACK_W-1:0]  ack_sr_q;
  logic [ACNT_W-1:0] ack_cnt_q;
  logic              full_q, term_q;

  wire [WORD_W-1:0] win_nxt = {win_q[WORD_W-2:0], bit_in};
  wire [WORD_W-1:0] asm_nxt = {asm_q[WORD_W-2:0], bit_in};

  wire sync_hit  = !sel_rx && st_q == S_HUNT && bit_strobe && win_nxt == SYNC_WORD;
  wire word_done = !sel_rx && st_q == S_RECV && bit_strobe && cnt_q == LAST_BIT;
  wire overrun   = word_done && full_q && !rd_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      win_q     <= '0;
      asm_q     <= '0;
      hold_q    <= '0;
      cnt_q     <= '0;
      ack_sr_q  <= '0;
      ack_cnt_q <= '0;
      term_q    <= 1'b0;
    end else if (sel_rx) begin
      st_q      <= S_HUNT;
      win_q     <= '0;
      term_q    <= 1'b0;
      ack_cnt_q <= '0;
    end else begin
      case (st_q)
        S_HUNT: if (bit_strobe) begin
          win_q <= win_nxt;
          if (sync_hit) begin
            st_q      <= S_RECV;
            cnt_q     <= '0;
            ack_sr_q  <= ACK_CODE;
            ack_cnt_q <= ACNT_W'(ACK_W);
          end
        end
        S_RECV: if (bit_strobe) begin
          asm_q <= asm_nxt;
          cnt_q <= cnt_q + CNT_W'(1);
          if (ack_cnt_q != '0) begin
            ack_sr_q  <= ack_sr_q << 1;
            ack_cnt_q <= ack_cnt_q - ACNT_W'(1);
          end
          if (word_done) begin
            cnt_q <= '0;
            if (overrun) begin
              st_q      <= S_IDLE;
              term_q    <= 1'b1;
              ack_cnt_q <= '0;
            end else begin
              hold_q <= asm_nxt;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      full_q <= 1'b0;
    else if (word_done && !overrun)  full_q <= 1'b1;
    else if (rd_stb)                 full_q <= 1'b0;
  end

  assign rd_data    = hold_q;
  assign full_rcv   = full_q;
  assign rx_armed   = st_q == S_RECV;
  assign ack_active = ack_cnt_q != '0;
  assign ack_out    = ack_active && ack_sr_q[ACK_W-1];
  assign term_flag  = term_q;

endmodule

// File: rtl/sync_word_rx_chk.sv
module sync_word_rx_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_rx,
  input logic              bit_strobe,
  input logic              rd_stb,
  input logic [WORD_W-1:0] rd_data,
  input logic              full_rcv,
  input logic              rx_armed,
  input logic              ack_out,
  input logic              ack_active,
  input logic              term_flag
);

  // R5
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_rcv) |-> $past(bit_strobe) && $past(rx_armed));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !bit_strobe && !sel_rx |=> !full_rcv);

  // R8
  term_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_flag) |-> !rx_armed && full_rcv && $stable(rd_data));

  // R9
  term_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_flag |-> !rx_armed);

  // R4
  ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_active |-> rx_armed) and (!ack_active |-> !ack_out));

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_strobe) |-> $stable(rd_data));

endmodule

bind sync_word_rx sync_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_rx(sel_rx), .bit_strobe(bit_strobe),
  .rd_stb(rd_stb), .rd_data(rd_data), .full_rcv(full_rcv),
  .rx_armed(rx_armed), .ack_out(ack_out), .ack_active(ack_active),
  .term_flag(term_flag)
);

// File: tb/test_sync_word_rx.sv
`timescale 1ns/1ps
module test_sync_word_rx;
  localparam logic [11:0] SYNC = 12'hE2D;
  localparam logic [2:0]  ACK  = 3'b101;
  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{12'h000, 12'hFFF, 12'hA5A, 12'h5A5, SYNC, 12'h801};

  logic clk = 0, rst_n = 0, sel_rx = 0, bit_strobe = 0, bit_in = 0, rd_stb = 0;
  logic [11:0] rd_data;
  logic full_rcv, rx_armed, ack_out, ack_active, term_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_word_rx i_sync_word_rx (
    .clk(clk), .rst_n(rst_n), .sel_rx(sel_rx), .bit_strobe(bit_strobe), .bit_in(bit_in),
    .rd_stb(rd_stb), .rd_data(rd_data), .full_rcv(full_rcv), .rx_armed(rx_armed),
    .ack_out(ack_out), .ack_active(ack_active), .term_flag(term_flag));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, logic rd = 0);
    bit_in = b; bit_strobe = 1; rd_stb = rd;
    @(negedge clk);
    bit_strobe = 0; rd_stb = 0; bit_in = ~b;
  endtask

  task automatic send_word(logic [11:0] w);
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_sel();
    sel_rx = 1; @(negedge clk); sel_rx = 0;
  endtask

  task automatic host_read(string req, logic [11:0] exp);
    chk(req, rd_data, exp);
    rd_stb = 1; @(negedge clk); rd_stb = 0;
    chk(req, full_rcv, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 armed", rx_armed, 0);
    chk("R1 full", full_rcv, 0);
    chk("R1 ack_active", ack_active, 0);
    chk("R1 ack_out", ack_out, 0);
    chk("R1 term", term_flag, 0);

    send_word(SYNC); send_word(12'h123);
    chk("R2 armed", rx_armed, 0);
    chk("R2 full", full_rcv, 0);

    pulse_sel();
    send_word(SYNC);
    chk("R3 armed", rx_armed, 1);
    begin
      logic [11:0] w = 12'h3C6;
      for (int i = 11; i >= 0; i--) begin
        if (i >= 9) begin
          chk("R4 ack_active", ack_active, 1);
          chk("R4 ack_out", ack_out, ACK[i-9]);
        end else if (i == 8) begin
          chk("R4 ack_active off", ack_active, 0);
          chk("R4 ack_out off", ack_out, 0);
        end
        if (i == 0) chk("R5 full before last", full_rcv, 0);
        send_bit(w[i]);
      end
      chk("R5 full", full_rcv, 1);
      host_read("R3 R6 first word", w);
    end

    for (int v = 0; v < NVEC; v++) begin
      send_word(VEC[v]);
      chk(v == 4 ? "R11 full" : "R5 full", full_rcv, 1);
      host_read(v == 4 ? "R11 data" : "R5 R6 data", VEC[v]);
      chk("R5 armed", rx_armed, 1);
    end

    begin
      logic [11:0] w = 12'h96C;
      for (int i = 11; i >= 6; i--) send_bit(w[i]);
      repeat (5) begin bit_in = ~bit_in; @(negedge clk); end
      for (int i = 5; i >= 0; i--) send_bit(w[i]);
      host_read("R10 data", w);
    end

    send_word(12'h4B1);
    for (int i = 11; i >= 1; i--) send_bit(12'h72E >> i);
    chk("R7 data before", rd_data, 12'h4B1);
    send_bit(1'b0, 1'b1);
    chk("R7 full", full_rcv, 1);
    chk("R7 armed", rx_armed, 1);
    chk("R7 term", term_flag, 0);
    chk("R7 data", rd_data, 12'h72E);

    send_word(12'h0F0);
    chk("R8 term", term_flag, 1);
    chk("R8 armed", rx_armed, 0);
    chk("R8 full", full_rcv, 1);
    chk("R8 data", rd_data, 12'h72E);
    chk("R8 ack", ack_active, 0);

    send_word(SYNC); send_word(12'h111);
    chk("R9 armed", rx_armed, 0);
    chk("R9 data", rd_data, 12'h72E);
    pulse_sel();
    chk("R9 term clear", term_flag, 0);
    send_word(12'h222);
    chk("R9 no sync armed", rx_armed, 0);
    chk("R9 no sync data", rd_data, 12'h72E);
    host_read("R9 old word", 12'h72E);
    send_word(SYNC);
    chk("R9 rearm", rx_armed, 1);
    send_word(12'h6D3);
    chk("R9 full", full_rcv, 1);
    host_read("R9 new word", 12'h6D3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule